// File: doc/BRIEF.md
# Descriptor Ring Fetch Controller

This block walks a ring of packet descriptors held in memory on behalf of one DMA channel. Each descriptor is four 32-bit words. A software-owned pad of zero to seven words follows each descriptor, and the engine never reads or writes those pad words. The engine reads the four words of the descriptor at its current address. If the ownership bit of the last word is set, it hands the whole descriptor to a downstream data mover. When the mover reports completion, the engine writes that last word back with the ownership bit cleared and steps to the next descriptor. After the last descriptor of the ring it returns to the ring base.

Software limits how far the engine may run with a tail register that holds an absolute byte address. When the current descriptor address equals that register, the engine stops before it reads anything. Any write to the tail register wakes the engine, which then fetches its current descriptor again. This lets software fully rewrite descriptors before it publishes them. If a fetched descriptor belongs to software, the engine raises a sticky buffer-unavailable flag and waits for a tail write. Software clears the flag by writing 1 to it.

Top module: `frf_ring_fetch`

## Requirements
- R1: After reset no memory request and no descriptor are presented, the unavailable flag is 0 and the current address reads 0.
- R2: Turning the run bit (bit 0 of register select 0) from 0 to 1 loads the current address from the base register (select 1). The engine then reads the words at current+0, +4, +8 and +12 in that order, with at most one read outstanding, and holds each request stable until it is accepted.
- R3: When the current address equals the tail register (select 3), the engine issues no descriptor read.
- R4: Any write to the tail register wakes a stopped or suspended engine, and it re-reads its current descriptor from word 0.
- R5: A descriptor whose fourth word has bit 31 set is presented as desc_data = {w3,w2,w1,w0} with desc_addr equal to its address, and it stays presented until desc_done.
- R6: A descriptor whose fourth word has bit 31 clear is not presented. The flag is set and stays set, and the engine issues no further reads until a tail write.
- R7: Writing 1 to bit 0 of register select 5 clears the flag, and writing 0 leaves it unchanged. A clear in the same cycle as a new suspension leaves the flag set.
- R8: On desc_done the engine writes the fourth word, with bit 31 cleared and other bits unchanged, to current+12. After that write is accepted, the current address advances by (4+skip)*4 bytes, where skip is bits 2:0 of select 4.
- R9: After the descriptor at index len-1 (len from select 2), the current address wraps to the base.
- R10: The pad words between descriptors are never read or written.
- R11: The engine never reads a descriptor at the tail address, even when descriptors at or past the tail are owned by hardware.
- R12: With the run bit at 0 the engine issues no reads, and a tail write does not wake it. A restart reloads the base address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select: 0 control, 1 base, 2 length, 3 tail, 4 skip, 5 status |
| cfg_wdata | input | 32 | Register write data |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 for write-back, 0 for read |
| mem_req_addr | output | 32 | Byte address of the word |
| mem_req_wdata | output | 32 | Write-back data |
| mem_rsp_valid | input | 1 | Read data valid (single beat) |
| mem_rsp_data | input | 32 | Read data |
| desc_valid | output | 1 | Descriptor presented to the data mover |
| desc_addr | output | 32 | Address of the presented descriptor |
| desc_data | output | 128 | Descriptor words {w3,w2,w1,w0} |
| desc_done | input | 1 | Completion from the data mover |
| unavail_flag | output | 1 | Sticky buffer-unavailable flag |
| dbg_cur_addr | output | 32 | Current descriptor address |

## Verification
Two events can land on the same clock edge. A software write-1 to clear the flag can arrive in the very cycle that the fourth word of a software-owned descriptor returns and sets the flag. The bench provokes this by injecting the status write from its memory model in the cycle it drives that response. Its reference model applies the clear first and the set second, so the flag must read 1 afterwards. A tail write arriving while the engine is in its check step is the second overlap. The engine keeps a pending wake for this case, so the model only has to confirm that no read ever starts at the tail address.

// File: rtl/frf_pkg.sv
package frf_pkg;
  localparam int ADDR_W     = 32;
  localparam int DESC_WORDS = 4;
  localparam int OWN_BIT    = 31;
  localparam int SKIP_W     = 3;

  typedef enum logic [2:0] {
    SEL_CTRL = 3'd0, SEL_BASE = 3'd1, SEL_LEN = 3'd2,
    SEL_TAIL = 3'd3, SEL_SKIP = 3'd4, SEL_STAT = 3'd5
  } frf_sel_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_RREQ, ST_RWAIT, ST_PRES, ST_WB, ST_SUSP, ST_TAIL
  } frf_state_e;

  // bytes between consecutive descriptors
  function automatic logic [ADDR_W-1:0] frf_stride(input logic [SKIP_W-1:0] skip);
    return ADDR_W'((DESC_WORDS + int'(skip)) * 4);
  endfunction

  // byte address of one word inside the current descriptor
  function automatic logic [ADDR_W-1:0] frf_word_addr(input logic [ADDR_W-1:0] cur,
                                                     input logic [1:0] w);
    return cur + {{(ADDR_W-4){1'b0}}, w, 2'b00};
  endfunction
endpackage

// File: rtl/frf_cfg_regs.sv
module frf_cfg_regs
  import frf_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  input  logic              flag_set,
  output logic              run,
  output logic              start,
  output logic              tail_wr,
  output logic [ADDR_W-1:0] base,
  output logic [LEN_W-1:0]  len,
  output logic [ADDR_W-1:0] tail,
  output logic [SKIP_W-1:0] skip,
  output logic              flag
);
  logic flag_clr;

  assign tail_wr  = cfg_we && (cfg_sel == SEL_TAIL);
  assign start    = cfg_we && (cfg_sel == SEL_CTRL) && cfg_wdata[0] && !run;
  assign flag_clr = cfg_we && (cfg_sel == SEL_STAT) && cfg_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run  <= 1'b0;
      base <= '0;
      len  <= '0;
      tail <= '0;
      skip <= '0;
      flag <= 1'b0;
    end else begin
      if (cfg_we) begin
        case (cfg_sel)
          SEL_CTRL: run  <= cfg_wdata[0];
          SEL_BASE: base <= cfg_wdata;
          SEL_LEN:  len  <= cfg_wdata[LEN_W-1:0];
          SEL_TAIL: tail <= cfg_wdata;
          SEL_SKIP: skip <= cfg_wdata[SKIP_W-1:0];
          default: ;
        endcase
      end
      // a new suspension outranks a clear in the same cycle
      if (flag_set)      flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
    end
  end

  assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set |=> flag);
  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !flag_clr) |=> flag);
  assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !flag_set) |=> !flag);
endmodule

// File: rtl/frf_fetch_engine.sv
module frf_fetch_engine
  import frf_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              start,
  input  logic              tail_wr,
  input  logic [ADDR_W-1:0] base,
  input  logic [LEN_W-1:0]  len,
  input  logic [ADDR_W-1:0] tail,
  input  logic [SKIP_W-1:0] skip,
  output logic              flag_set,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [31:0]       mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data,
  output logic              desc_valid,
  output logic [ADDR_W-1:0] desc_addr,
  output logic [DESC_WORDS*32-1:0] desc_data,
  input  logic              desc_done,
  output logic [ADDR_W-1:0] cur_addr
);
  localparam logic [31:0] OWN_MASK = 32'h1 << OWN_BIT;

  frf_state_e        st;
  logic [ADDR_W-1:0] cur;
  logic [LEN_W-1:0]  idx;
  logic [1:0]        wsel;
  logic [31:0]       words [DESC_WORDS];
  logic              wake_pend;
  logic              rd_pend;

  // named events
  logic at_tail, rd_acc, wb_acc, rsp_last, owned, wrap_now;
  logic [ADDR_W-1:0] next_cur;
  logic [LEN_W:0]    idx_inc;

  assign at_tail  = (cur == tail);
  assign rd_acc   = mem_req_valid && mem_req_ready && !mem_req_write;
  assign wb_acc   = mem_req_valid && mem_req_ready && mem_req_write;
  assign rsp_last = (st == ST_RWAIT) && mem_rsp_valid && (wsel == 2'd3);
  assign owned    = mem_rsp_data[OWN_BIT];
  assign flag_set = rsp_last && !owned;
  assign idx_inc  = {1'b0, idx} + 1'b1;
  assign wrap_now = (idx_inc >= {1'b0, len});
  assign next_cur = wrap_now ? base : cur + frf_stride(skip);

  assign mem_req_valid = (st == ST_RREQ) || (st == ST_WB);
  assign mem_req_write = (st == ST_WB);
  assign mem_req_addr  = frf_word_addr(cur, (st == ST_WB) ? 2'd3 : wsel);
  assign mem_req_wdata = words[3] & ~OWN_MASK;
  assign desc_valid    = (st == ST_PRES);
  assign desc_addr     = cur;
  assign cur_addr      = cur;

  genvar g;
  generate
    for (g = 0; g < DESC_WORDS; g++) begin : g_pack
      assign desc_data[g*32 +: 32] = words[g];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cur       <= '0;
      idx       <= '0;
      wsel      <= '0;
      wake_pend <= 1'b0;
      rd_pend   <= 1'b0;
      for (int i = 0; i < DESC_WORDS; i++) words[i] <= '0;
    end else begin
      if (tail_wr)              wake_pend <= 1'b1;
      else if (st == ST_CHECK)  wake_pend <= 1'b0;

      if (rd_acc)             rd_pend <= 1'b1;
      else if (mem_rsp_valid) rd_pend <= 1'b0;

      case (st)
        ST_IDLE:  if (run) st <= ST_CHECK;
        ST_CHECK: begin
          if (!run)        st <= ST_IDLE;
          else if (at_tail) st <= ST_TAIL;
          else begin
            st   <= ST_RREQ;
            wsel <= 2'd0;
          end
        end
        ST_RREQ:  if (mem_req_ready) st <= ST_RWAIT;
        ST_RWAIT: if (mem_rsp_valid) begin
          words[wsel] <= mem_rsp_data;
          if (wsel == 2'd3) st <= owned ? ST_PRES : ST_SUSP;
          else begin
            wsel <= wsel + 2'd1;
            st   <= ST_RREQ;
          end
        end
        ST_PRES:  if (desc_done) st <= ST_WB;
        ST_WB:    if (mem_req_ready) begin
          cur <= next_cur;
          idx <= wrap_now ? '0 : idx_inc[LEN_W-1:0];
          st  <= ST_CHECK;
        end
        ST_SUSP, ST_TAIL: begin
          if (!run)                       st <= ST_IDLE;
          else if (wake_pend || tail_wr)  st <= ST_CHECK;
        end
        default: st <= ST_IDLE;
      endcase

      if (start) begin
        cur <= base;
        idx <= '0;
      end
    end
  end

  assert_one_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_write) |-> !rd_pend);
  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
  assert_tail_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_req_valid) && !mem_req_write && wsel == 2'd0) |-> ($past(cur) != $past(tail)));
  assert_desc_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && !desc_done) |=> (desc_valid && $stable(desc_addr) && $stable(desc_data)));
  assert_wb_own_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write) |-> (!mem_req_wdata[OWN_BIT] && mem_req_addr == desc_addr + 32'd12));
  assert_suspend_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SUSP && !tail_wr && !wake_pend) |=> !mem_req_valid);
endmodule

// File: rtl/frf_ring_fetch.sv
module frf_ring_fetch
  import frf_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_we,
  input  logic [2:0]   cfg_sel,
  input  logic [31:0]  cfg_wdata,
  output logic         mem_req_valid,
  input  logic         mem_req_ready,
  output logic         mem_req_write,
  output logic [31:0]  mem_req_addr,
  output logic [31:0]  mem_req_wdata,
  input  logic         mem_rsp_valid,
  input  logic [31:0]  mem_rsp_data,
  output logic         desc_valid,
  output logic [31:0]  desc_addr,
  output logic [127:0] desc_data,
  input  logic         desc_done,
  output logic         unavail_flag,
  output logic [31:0]  dbg_cur_addr
);
  logic              run, start, tail_wr, flag_set;
  logic [ADDR_W-1:0] base, tail;
  logic [LEN_W-1:0]  len;
  logic [SKIP_W-1:0] skip;

  frf_cfg_regs #(.LEN_W(LEN_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .flag_set(flag_set), .run(run), .start(start),
    .tail_wr(tail_wr), .base(base), .len(len), .tail(tail), .skip(skip),
    .flag(unavail_flag)
  );

  frf_fetch_engine #(.LEN_W(LEN_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .run(run), .start(start), .tail_wr(tail_wr),
    .base(base), .len(len), .tail(tail), .skip(skip), .flag_set(flag_set),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .desc_valid(desc_valid),
    .desc_addr(desc_addr), .desc_data(desc_data), .desc_done(desc_done),
    .cur_addr(dbg_cur_addr)
  );
endmodule

// File: tb/frf_ring_fetch_test.sv
module frf_ring_fetch_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        t_we = 1'b0, r_we = 1'b0;
  logic [2:0]  t_sel = '0;
  logic [31:0] t_data = '0;
  logic        cfg_we;
  logic [2:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  assign cfg_we    = t_we | r_we;
  assign cfg_sel   = r_we ? 3'd5 : t_sel;
  assign cfg_wdata = r_we ? 32'd1 : t_data;

  logic         mem_req_valid, mem_req_write, desc_valid, unavail_flag;
  logic         mem_req_ready = 1'b0, mem_rsp_valid = 1'b0, desc_done = 1'b0;
  logic [31:0]  mem_req_addr, mem_req_wdata, desc_addr, dbg_cur_addr;
  logic [31:0]  mem_rsp_data = '0;
  logic [127:0] desc_data;

  frf_ring_fetch uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .desc_valid(desc_valid), .desc_addr(desc_addr),
    .desc_data(desc_data), .desc_done(desc_done), .unavail_flag(unavail_flag),
    .dbg_cur_addr(dbg_cur_addr)
  );

  int checks = 0, failures = 0, cyc = 0, pres = 0, hold = 0, mword = 0, midx = 0;
  logic [31:0] mem [256];
  logic [31:0] mcur = 0, mbase = 0, mtail = 0, mlen = 0, mskip = 0;
  logic mrun = 0, mflag = 0, pend_unown = 0, race_arm = 0, p_dv = 0, p_done = 0;
  logic p_rd = 0, p_wb = 0;
  logic [31:0] p_addr = 0, p_wdata = 0;
  bit done_run = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] stride();
    return (32'd4 + mskip) * 32'd4;
  endfunction

  // reference model, compared every clock at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (cfg_we) begin
        case (cfg_sel)
          3'd0: begin
            if (cfg_wdata[0] && !mrun) begin mcur = mbase; midx = 0; end
            mrun = cfg_wdata[0];
          end
          3'd1: mbase = cfg_wdata;
          3'd2: mlen  = {16'd0, cfg_wdata[15:0]};
          3'd3: mtail = cfg_wdata;
          3'd4: mskip = {29'd0, cfg_wdata[2:0]};
          3'd5: if (cfg_wdata[0]) mflag = 1'b0;
          default: ;
        endcase
      end
      r_we = 1'b0;
      if (pend_unown) begin mflag = 1'b1; pend_unown = 1'b0; end
      if (p_wb) begin
        chk(p_addr == mcur + 12, "R8 wb addr", p_addr, mcur + 12);
        chk(p_wdata == (mem[(mcur[9:2] + 3) & 8'hff] & 32'h7fff_ffff), "R8 wb data",
            p_wdata, mem[(mcur[9:2] + 3) & 8'hff] & 32'h7fff_ffff);
        mem[p_addr[9:2]] = p_wdata;
        if (midx + 1 >= ((mlen == 0) ? 1 : int'(mlen))) begin mcur = mbase; midx = 0; end
        else begin mcur = mcur + stride(); midx++; end
      end
      mem_rsp_valid = 1'b0;
      if (p_rd) begin
        chk(p_addr == mcur + 4 * mword, "R2/R10 read addr", p_addr, mcur + 4 * mword);
        if (mword == 0) chk(mcur != mtail, "R3/R11 read at tail", mcur, mtail);
        chk(mrun, "R12 read while stopped", {31'd0, mrun}, 32'd1);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem[p_addr[9:2]];
        if (mword == 3 && !mem_rsp_data[31]) begin
          pend_unown = 1'b1;
          if (race_arm) begin r_we = 1'b1; race_arm = 1'b0; end
        end
        mword = (mword + 1) % 4;
      end
      chk(dbg_cur_addr == mcur, "R8/R9 current address", dbg_cur_addr, mcur);
      chk(unavail_flag == mflag, "R6/R7 flag", {31'd0, unavail_flag}, {31'd0, mflag});
      if (p_dv && !p_done) chk(desc_valid, "R5 hold", {31'd0, desc_valid}, 32'd1);
      if (desc_valid && !p_dv) begin
        pres++;
        chk(desc_addr == mcur, "R5 desc addr", desc_addr, mcur);
        for (int k = 0; k < 4; k++)
          chk(desc_data[k*32 +: 32] == mem[(mcur[9:2] + k) & 8'hff], "R5 desc word",
              desc_data[k*32 +: 32], mem[(mcur[9:2] + k) & 8'hff]);
        chk(desc_data[127], "R5 owned", {31'd0, desc_data[127]}, 32'd1);
      end
    end
    p_dv = desc_valid;
    hold = desc_valid ? hold + 1 : 0;
    desc_done = desc_valid && (hold == 2);
    p_done = desc_done;
    mem_req_ready = (cyc % 4) != 1;
    p_rd = mem_req_valid && mem_req_ready && !mem_req_write;
    p_wb = mem_req_valid && mem_req_ready && mem_req_write;
    p_addr = mem_req_addr;
    p_wdata = mem_req_wdata;
  end

  task automatic wcfg(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk); #1;
    t_we = 1'b1; t_sel = sel; t_data = d;
    @(negedge clk); #1;
    t_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  localparam logic [31:0] BASE = 32'h100;
  function automatic logic [31:0] daddr(input int i);
    return BASE + i * 24;
  endfunction
  task automatic set_desc(input int i, input bit own);
    for (int k = 0; k < 4; k++) mem[daddr(i)/4 + k] = 32'hA000_0000 | (i << 8) | k;
    mem[daddr(i)/4 + 3] = {own, 7'd0, 24'(i * 256 + 3)};
  endtask

  initial begin
    for (int a = 0; a < 256; a++) mem[a] = 32'h5EED_0000 | a;
    repeat (3) @(negedge clk);
    #2;
    chk(!mem_req_valid && !desc_valid, "R1 idle outputs", {30'd0, mem_req_valid, desc_valid}, 0);
    chk(!unavail_flag, "R1 flag", {31'd0, unavail_flag}, 0);
    chk(dbg_cur_addr == 0, "R1 cur", dbg_cur_addr, 0);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 4; i++) set_desc(i, 1'b1);
    wcfg(3'd1, BASE); wcfg(3'd2, 32'd4); wcfg(3'd4, 32'd2); wcfg(3'd3, daddr(3));
    wcfg(3'd0, 32'd1);
    idle(150);
    chk(pres == 3, "R2/R5 three presented", pres, 3);
    chk(dbg_cur_addr == daddr(3), "R3 stop at tail", dbg_cur_addr, daddr(3));
    wcfg(3'd3, BASE);
    idle(80);
    chk(pres == 4, "R4/R9 wake then wrap", pres, 4);
    chk(dbg_cur_addr == BASE, "R9 wrap to base", dbg_cur_addr, BASE);
    set_desc(0, 1'b1); set_desc(1, 1'b0);
    idle(60);
    chk(pres == 4, "R11 owned at tail not read", pres, 4);
    wcfg(3'd3, daddr(2));
    idle(80);
    chk(pres == 5 && unavail_flag, "R6 suspend", {pres[30:0], unavail_flag}, {31'd5, 1'b1});
    chk(dbg_cur_addr == daddr(1), "R6 parked", dbg_cur_addr, daddr(1));
    wcfg(3'd5, 32'd0); idle(2);
    chk(unavail_flag, "R7 write 0 keeps", {31'd0, unavail_flag}, 1);
    wcfg(3'd5, 32'd1); idle(2);
    chk(!unavail_flag, "R7 write 1 clears", {31'd0, unavail_flag}, 0);
    set_desc(1, 1'b1);
    wcfg(3'd3, daddr(2));
    idle(80);
    chk(pres == 6 && dbg_cur_addr == daddr(2), "R4 refetch same tail", dbg_cur_addr, daddr(2));
    set_desc(2, 1'b0); race_arm = 1'b1;
    wcfg(3'd3, BASE);
    idle(80);
    chk(unavail_flag && !race_arm, "R7 set beats clear", {31'd0, unavail_flag}, 1);
    wcfg(3'd5, 32'd1);
    wcfg(3'd0, 32'd0); idle(10);
    wcfg(3'd3, daddr(3)); idle(40);
    chk(pres == 6 && dbg_cur_addr == daddr(2), "R12 stopped ignores tail", pres, 6);
    set_desc(0, 1'b1); set_desc(1, 1'b0);
    wcfg(3'd0, 32'd1); idle(2);
    chk(dbg_cur_addr == BASE || pres == 6, "R12 restart at base", dbg_cur_addr, BASE);
    idle(100);
    chk(pres == 7 && dbg_cur_addr == daddr(1), "R12 restart fetch", dbg_cur_addr, daddr(1));
    for (int i = 0; i < 4; i++)
      for (int k = 4; k < 6; k++)
        chk(mem[daddr(i)/4 + k] == (32'h5EED_0000 | (daddr(i)/4 + k)), "R10 pad untouched",
            mem[daddr(i)/4 + k], 32'h5EED_0000 | (daddr(i)/4 + k));
    done_run = 1;
  end

  initial begin
    fork
      wait (done_run);
      begin
        repeat (20000) @(posedge clk);
        failures++; checks++;
        $display("FAIL watchdog actual=%0d expected=done", 20000);
      end
    join_any
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule